// File: doc/BRIEF.md
# Serial Controller Interrupt Combiner

This block merges the four interrupt sources of a serial controller (line status error, received data available, transmit holding register empty and modem status change) into a single interrupt request line. Each source has a pending flag that the serial datapath sets with a one-cycle event pulse. The flag stays set until the host performs the register access that services it. A per-source enable mask, loaded by writes to the enable register, decides which pending flags can reach the line. An identification code reports the highest-priority enabled source.

A mode input selects how the line behaves while several sources are waiting. In level mode the line stays high for as long as any enabled source is pending. In legacy mode the line drops for exactly one clock cycle after each service that leaves other sources pending. This gives an edge-triggered interrupt controller a fresh rising edge for each remaining source. A second output ANDs the line with the host's active-low access strobe. A controller wired to it therefore sees a new edge after every host access. The host must tolerate one spurious interrupt from this output.

Top module: `serial_irq_gen`

## Requirements
- R1: A one-cycle pulse on a source's event input sets that source's pending flag at the next clock edge. While any pending source is enabled and no legacy drop is in progress, `irqOut` is 1. `irqOut` is never 1 while no enabled source is pending.
- R2: A write to the enable register loads `ierData` with this layout: bit 0 enables receive data, bit 1 enables transmit empty, bit 2 enables line status, bit 3 enables modem status. Writing all zeros drops `irqOut`. Writing the bits back raises `irqOut` again if an enabled source is still pending.
- R3: `irqCode` reports the highest enabled pending source. Priority runs line status, then receive data, then transmit empty, then modem status. The codes are 4'b0110 for line status, 4'b0100 for receive data, 4'b0010 for transmit empty, 4'b0000 for modem status, and 4'b0001 when nothing enabled is pending.
- R4: A line status read clears the line status flag and the receive flag. A receive buffer read clears the receive flag. A modem status read clears the modem flag.
- R5: A transmit holding write clears the transmit flag. An identification read also clears it, but only when `irqCode` shows transmit empty in that cycle. An identification read while a higher source is reported leaves the transmit flag set.
- R6: In level mode (`legacyMode`=0), after a service that leaves another enabled source pending, `irqOut` stays 1 in every following cycle.
- R7: In legacy mode (`legacyMode`=1), after a service that clears a pending enabled source and leaves another one pending, `irqOut` is 0 for exactly the one cycle after the servicing edge and 1 again in the next cycle.
- R8: `irqGated` equals `irqOut` AND `accessN`, so it is 0 in any cycle where `accessN` is 0.
- R9: An event pulse and a clearing access for the same source in the same cycle leave the flag set.
- R10: After reset all flags and enables are 0, `irqOut` and `irqGated` are 0, and `irqCode` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| legacyMode | input | 1 | 1 selects the pulse-per-service behaviour |
| accessN | input | 1 | Active-low host access strobe for the gated output |
| srcEvent | input | 4 | Event pulses: bit 0 receive, bit 1 transmit empty, bit 2 line status, bit 3 modem |
| wrIer | input | 1 | Enable register write strobe |
| ierData | input | 4 | Enable mask written by `wrIer` |
| rdLsr | input | 1 | Line status register read strobe |
| rdRbr | input | 1 | Receive buffer read strobe |
| rdIir | input | 1 | Identification register read strobe |
| wrThr | input | 1 | Transmit holding register write strobe |
| rdMsr | input | 1 | Modem status register read strobe |
| irqOut | output | 1 | Interrupt request line |
| irqGated | output | 1 | Interrupt line ANDed with `accessN` |
| irqCode | output | 4 | Identification code of the top enabled source |

## Verification
The bench checks an identification read made while line status outranks a pending transmit-empty source. A design that clears the transmit flag on any identification read would lose that interrupt. It checks a set and a clear that arrive in the same cycle, where clear priority would drop a fresh event. It measures the legacy drop cycle by cycle: a stretched drop, a missing drop or a drop in level mode each show up as a wrong `irqOut` value. It also checks that disabling every source and then re-enabling them brings the line back up while a source is still pending.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int NUM_SRC   = 4;
  localparam int CODE_W    = 4;
  localparam int SRC_RX    = 0;
  localparam int SRC_TX    = 1;
  localparam int SRC_LINE  = 2;
  localparam int SRC_MODEM = 3;

  localparam logic [CODE_W-1:0] CODE_NONE  = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_LINE  = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_RX    = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TX    = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_MODEM = 4'b0000;

  typedef struct packed {
    logic               ldEnable;
    logic [NUM_SRC-1:0] clr;
  } ctlStrobe_t;
endpackage

// File: rtl/serial_irq_flags.sv
module serial_irq_flags
  import serial_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] ierData,
  input  ctlStrobe_t         strobes,
  output logic [NUM_SRC-1:0] active
);
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] enable;

  always_ff @(posedge clk) begin
    if (!rstN) enable <= '0;
    else if (strobes.ldEnable) enable <= ierData;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) pending[i] <= 1'b0;
      else if (srcEvent[i]) pending[i] <= 1'b1;
      else if (strobes.clr[i]) pending[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      srcEvent[i] |=> pending[i]); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clr[i] && !srcEvent[i]) |=> !pending[i]); // R4
  end

  assign active = pending & enable;
endmodule

// File: rtl/serial_irq_ctrl.sv
module serial_irq_ctrl
  import serial_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               legacyMode,
  input  logic               accessN,
  input  logic [NUM_SRC-1:0] active,
  input  logic               wrIer,
  input  logic               rdLsr,
  input  logic               rdRbr,
  input  logic               rdIir,
  input  logic               wrThr,
  input  logic               rdMsr,
  output ctlStrobe_t         strobes,
  output logic               irqOut,
  output logic               irqGated,
  output logic [CODE_W-1:0]  irqCode
);
  logic topIsTx;
  logic rawIrq;
  logic svcQ;

  always_comb begin
    irqCode = CODE_NONE;
    if (active[SRC_MODEM]) irqCode = CODE_MODEM;
    if (active[SRC_TX])    irqCode = CODE_TX;
    if (active[SRC_RX])    irqCode = CODE_RX;
    if (active[SRC_LINE])  irqCode = CODE_LINE;
  end

  assign topIsTx = active[SRC_TX] & ~active[SRC_RX] & ~active[SRC_LINE];

  always_comb begin
    strobes                = '0;
    strobes.ldEnable       = wrIer;
    strobes.clr[SRC_LINE]  = rdLsr;
    strobes.clr[SRC_RX]    = rdRbr | rdLsr;
    strobes.clr[SRC_TX]    = wrThr | (rdIir & topIsTx);
    strobes.clr[SRC_MODEM] = rdMsr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) svcQ <= 1'b0;
    else svcQ <= |(strobes.clr & active);
  end

  assign rawIrq   = |active;
  assign irqOut   = rawIrq & ~(legacyMode & svcQ);
  assign irqGated = irqOut & accessN;

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (active == '0) |-> (irqCode == CODE_NONE)); // R3
  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    active[SRC_LINE] |-> (irqCode == CODE_LINE)); // R3
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (active != '0)); // R1
  AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyMode && (active != '0)) |-> irqOut); // R6
endmodule

// File: rtl/serial_irq_gen.sv
module serial_irq_gen
  import serial_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               legacyMode,
  input  logic               accessN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               wrIer,
  input  logic [NUM_SRC-1:0] ierData,
  input  logic               rdLsr,
  input  logic               rdRbr,
  input  logic               rdIir,
  input  logic               wrThr,
  input  logic               rdMsr,
  output logic               irqOut,
  output logic               irqGated,
  output logic [CODE_W-1:0]  irqCode
);
  ctlStrobe_t         strobes;
  logic [NUM_SRC-1:0] active;

  serial_irq_flags u_flags (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .ierData(ierData),
    .strobes(strobes), .active(active)
  );

  serial_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .accessN(accessN),
    .active(active), .wrIer(wrIer), .rdLsr(rdLsr), .rdRbr(rdRbr),
    .rdIir(rdIir), .wrThr(wrThr), .rdMsr(rdMsr), .strobes(strobes),
    .irqOut(irqOut), .irqGated(irqGated), .irqCode(irqCode)
  );
endmodule

// File: tb/sim_serial_irq_gen.sv
`timescale 1ns/1ps
module sim_serial_irq_gen;
  logic       clk = 1'b0;
  logic       rstN;
  logic       legacyMode, accessN, wrIer, rdLsr, rdRbr, rdIir, wrThr, rdMsr;
  logic [3:0] srcEvent, ierData;
  logic       irqOut, irqGated;
  logic [3:0] irqCode;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;

  always #2.5 clk = ~clk;

  serial_irq_gen u0 (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .accessN(accessN),
    .srcEvent(srcEvent), .wrIer(wrIer), .ierData(ierData), .rdLsr(rdLsr),
    .rdRbr(rdRbr), .rdIir(rdIir), .wrThr(wrThr), .rdMsr(rdMsr),
    .irqOut(irqOut), .irqGated(irqGated), .irqCode(irqCode)
  );

  // Entry: {expCode[4], expIrq, rdMsr, wrThr, rdIir, rdRbr, rdLsr, ierData[4], wrIer, srcEvent[4]}
  // srcEvent bits: 0 rx, 1 tx, 2 line, 3 modem. Level mode throughout.
  localparam int NVEC = 12;
  localparam logic [18:0] VEC [NVEC] = '{
    {4'b0001, 1'b0, 5'b00000, 4'b1111, 1'b1, 4'b0000}, // R2 enable all, nothing pending
    {4'b0100, 1'b1, 5'b00000, 4'b0000, 1'b0, 4'b0001}, // R1 rx pending
    {4'b0100, 1'b1, 5'b00000, 4'b0000, 1'b0, 4'b1000}, // R3 modem below rx
    {4'b0110, 1'b1, 5'b00000, 4'b0000, 1'b0, 4'b0100}, // R3 line on top
    {4'b0110, 1'b1, 5'b00100, 4'b0000, 1'b0, 4'b0000}, // R5 id read, no tx
    {4'b0000, 1'b1, 5'b00001, 4'b0000, 1'b0, 4'b0000}, // R4 lsr read clears line+rx
    {4'b0010, 1'b1, 5'b00000, 4'b0000, 1'b0, 4'b0010}, // R3 tx above modem
    {4'b0000, 1'b1, 5'b00100, 4'b0000, 1'b0, 4'b0000}, // R5 id read clears tx on top
    {4'b0001, 1'b0, 5'b10000, 4'b0000, 1'b0, 4'b0000}, // R4 msr read clears modem
    {4'b0001, 1'b0, 5'b00000, 4'b0000, 1'b1, 4'b0010}, // R2 tx set while all disabled
    {4'b0010, 1'b1, 5'b00000, 4'b0010, 1'b1, 4'b0000}, // R2 enable tx only
    {4'b0001, 1'b0, 5'b01000, 4'b0000, 1'b0, 4'b0000}  // R5 thr write clears tx
  };

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      finishRun();
    end
  end

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, sample just after the rising edge.
  task automatic cyc(logic [3:0] ev, logic wi, logic [3:0] id, logic ls,
                     logic rb, logic ii, logic th, logic ms);
    @(negedge clk);
    srcEvent = ev; wrIer = wi; ierData = id; rdLsr = ls;
    rdRbr = rb; rdIir = ii; wrThr = th; rdMsr = ms;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    cyc(4'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; legacyMode = 1'b0; accessN = 1'b1;
    srcEvent = '0; wrIer = 0; ierData = '0;
    rdLsr = 0; rdRbr = 0; rdIir = 0; wrThr = 0; rdMsr = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 irqOut", {3'b0, irqOut}, 4'b0000);
    check("R10 irqGated", {3'b0, irqGated}, 4'b0000);
    check("R10 irqCode", irqCode, 4'b0001);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][3:0], VEC[i][4], VEC[i][8:5], VEC[i][9], VEC[i][10],
          VEC[i][11], VEC[i][12], VEC[i][13]);
      check($sformatf("R1/R3 table row %0d irqOut", i), {3'b0, irqOut}, {3'b0, VEC[i][14]});
      check($sformatf("R3 table row %0d irqCode", i), irqCode, VEC[i][18:15]);
    end

    // R9: event and clear for rx in the same cycle keep the flag set
    cyc(4'b0000, 1'b1, 4'b1111, 0, 0, 0, 0, 0);
    cyc(4'b0001, 1'b0, 4'b0000, 0, 1, 0, 0, 0);
    check("R9 set beats clear", irqCode, 4'b0100);
    cyc(4'b0000, 1'b0, 4'b0000, 0, 1, 0, 0, 0);
    check("R4 rbr read clears rx", irqCode, 4'b0001);

    // R5: id read while line is reported leaves tx pending
    cyc(4'b0110, 1'b0, 4'b0000, 0, 0, 0, 0, 0);
    cyc(4'b0000, 1'b0, 4'b0000, 0, 0, 1, 0, 0);
    check("R5 id read under line", irqCode, 4'b0110);
    cyc(4'b0000, 1'b0, 4'b0000, 1, 0, 0, 0, 0);
    check("R5 tx survives", irqCode, 4'b0010);
    cyc(4'b0000, 1'b0, 4'b0000, 0, 0, 0, 1, 0);
    check("R5 thr write clears", irqCode, 4'b0001);

    // R6: level mode holds the line across a service
    cyc(4'b1001, 1'b0, 4'b0000, 0, 0, 0, 0, 0);
    cyc(4'b0000, 1'b0, 4'b0000, 0, 1, 0, 0, 0);
    check("R6 level after service", {3'b0, irqOut}, 4'b0001);
    idle();
    check("R6 level next cycle", {3'b0, irqOut}, 4'b0001);

    // R8: gated output follows the access strobe
    @(negedge clk); accessN = 1'b0; #1;
    check("R8 gated low on access", {3'b0, irqGated}, 4'b0000);
    check("R8 line unaffected", {3'b0, irqOut}, 4'b0001);
    @(negedge clk); accessN = 1'b1; #1;
    check("R8 gated high after access", {3'b0, irqGated}, 4'b0001);

    // R2: disable all drops the line, re-enable re-raises it (modem still pending)
    cyc(4'b0000, 1'b1, 4'b0000, 0, 0, 0, 0, 0);
    check("R2 disable drops", {3'b0, irqOut}, 4'b0000);
    cyc(4'b0000, 1'b1, 4'b1000, 0, 0, 0, 0, 0);
    check("R2 re-enable raises", {3'b0, irqOut}, 4'b0001);
    cyc(4'b0000, 1'b1, 4'b1111, 0, 0, 0, 0, 0);

    // R7: legacy mode drops for exactly one cycle after a service
    legacyMode = 1'b1;
    cyc(4'b0001, 1'b0, 4'b0000, 0, 0, 0, 0, 0);
    check("R7 legacy before service", {3'b0, irqOut}, 4'b0001);
    cyc(4'b0000, 1'b0, 4'b0000, 0, 1, 0, 0, 0);
    check("R7 legacy drop cycle", {3'b0, irqOut}, 4'b0000);
    check("R7 modem still reported", irqCode, 4'b0000);
    idle();
    check("R7 legacy rises again", {3'b0, irqOut}, 4'b0001);
    idle();
    check("R7 legacy stays high", {3'b0, irqOut}, 4'b0001);
    cyc(4'b0000, 1'b0, 4'b0000, 0, 0, 0, 0, 1);
    check("R7 last service leaves low", {3'b0, irqOut}, 4'b0000);
    idle();
    check("R7 idle stays low", {3'b0, irqOut}, 4'b0000);

    finishRun();
  end
endmodule